// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes a mono audio stream carried on three lines (serial data, bit clock, word clock) and turns it into parallel samples in the system clock domain. Data bits are shifted in most significant bit first on each rising bit clock edge. A rising word clock edge closes the word. The word is the last 20 or 24 bits shifted in, so the final bit before that edge is the LSB. Because the word is aligned to its end, the burst of bit clocks may sit anywhere in the word period, and any earlier bit clocks simply fall out of the shift register.

The closed word is registered on the word clock edge into a holding register, formatted to a 24-bit two's complement value as it is stored. A toggle flag announces it to the system clock domain, where a two-flop synchronizer detects the flag change. The system side then re-registers the held word and raises a valid pulse for one cycle. A length select input chooses 24-bit words (high) or 20-bit words (low). A 20-bit word lands in the upper 20 bits of the output with the four low bits zero, so its sign stays in bit 23.

Top module: `rjrx_top`

## Requirements
- R1: Serial data is sampled on each rising edge of the bit clock and is taken most significant bit first.
- R2: With the length select high at a rising word clock edge, the 24 bits most recently shifted in form the sample, the last bit before the edge being bit 0 of smp_data.
- R3: With the length select low at a rising word clock edge, the 20 bits most recently shifted in appear on smp_data[23:4] (last bit on bit 4) and smp_data[3:0] is zero.
- R4: Bit clock cycles that come before the final 20 or 24 of a word have no effect on the sample.
- R5: The bit clock may stop for any length of time between the last data bit and the word clock edge without changing the sample.
- R6: Every rising word clock edge produces exactly one smp_valid pulse, one system clock cycle wide, carrying that word.
- R7: smp_data changes only in a cycle where smp_valid is high, and holds its value between pulses.
- R8: While reset is asserted, smp_valid is low and smp_data is zero.
- R9: The length select applies word by word, as sampled on each closing word clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bclk | input | 1 | Serial bit clock, data sampled on rising edge |
| ser_wclk | input | 1 | Word clock, rising edge closes a word |
| ser_data | input | 1 | Serial data, MSB first |
| len24_sel | input | 1 | Word length select: 1 = 24 bits, 0 = 20 bits |
| smp_data | output | 24 | Received two's complement sample |
| smp_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench aims at the word boundary: extra leading bit clocks that a design aligned to the first bit would keep, and a long idle gap before the word clock edge that a design closing the word on a bit count would not survive. It checks both full-scale extremes in both lengths, where a wrong 20-bit placement would lose the sign or leave bits in the low nibble. It switches the length select between consecutive words, which catches a design that latches the select once. It also counts valid pulses against words sent, so a doubled, lost or widened pulse shows up.

// File: rtl/rjrx_pkg.sv
`timescale 1ns/1ps
package rjrx_pkg;
  localparam int unsigned SAMPLE_W   = 24;
  localparam int unsigned SHORT_W    = 20;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/rjrx_shift.sv
`timescale 1ns/1ps
// Bit clock domain: free-running shift register, MSB arrives first.
module rjrx_shift #(
  parameter int unsigned W = 24
) (
  input  logic         bclk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] shreg_o
);
  logic [W-1:0] shift_q, shift_d;

  always_comb begin
    shift_d = {shift_q[W-2:0], din};
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign shreg_o = shift_q;
endmodule

// File: rtl/rjrx_wcap.sv
`timescale 1ns/1ps
// Word clock domain: captures and formats the closed word, flips a flag.
module rjrx_wcap #(
  parameter int unsigned W  = 24,
  parameter int unsigned SW = 20
) (
  input  logic         wclk,
  input  logic         rst_n,
  input  logic         sel_long,
  input  logic [W-1:0] shreg_i,
  output logic [W-1:0] word_o,
  output logic         tog_o
);
  localparam int unsigned PAD = W - SW;

  logic [W-1:0] word_q, word_d;
  logic         tog_q, tog_d;
  logic [W-1:0] short_fmt;

  generate
    if (PAD == 0) begin : g_nopad
      assign short_fmt = shreg_i;
    end else begin : g_pad
      assign short_fmt = {shreg_i[SW-1:0], {PAD{1'b0}}};
      // R3
      short_pad_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !sel_long |=> (word_q[PAD-1:0] == '0));
    end
  endgenerate

  always_comb begin
    word_d = sel_long ? shreg_i : short_fmt;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      tog_q  <= tog_d;
    end
  end

  // R2
  long_copy_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    sel_long |=> (word_q == $past(shreg_i)));

  assign word_o = word_q;
  assign tog_o  = tog_q;
endmodule

// File: rtl/rjrx_cdc.sv
`timescale 1ns/1ps
// System clock domain: reset synchronizer, flag synchronizer, output stage.
module rjrx_cdc #(
  parameter int unsigned W      = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tog_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  logic [1:0]        rsync_q;
  logic              srst_n;
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              pulse;
  logic [W-1:0]      data_q, data_d;
  logic              valid_q, valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  always_comb begin
    sync_d  = {sync_q[STAGES-2:0], tog_i};
    prev_d  = sync_q[STAGES-1];
    pulse   = sync_q[STAGES-1] ^ prev_q;
    data_d  = pulse ? word_i : data_q;
    valid_d = pulse;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!srst_n)
    valid_o |=> !valid_o);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(data_o) |-> valid_o);

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!valid_o && data_o == '0)
        else $error("reset state violated");
    end
  end
endmodule

// File: rtl/rjrx_top.sv
`timescale 1ns/1ps
module rjrx_top #(
  parameter int unsigned SAMPLE_W   = rjrx_pkg::SAMPLE_W,
  parameter int unsigned SHORT_W    = rjrx_pkg::SHORT_W,
  parameter int unsigned SYNC_DEPTH = rjrx_pkg::SYNC_DEPTH
) (
  input  logic                clk_sys,
  input  logic                rst_n,
  input  logic                ser_bclk,
  input  logic                ser_wclk,
  input  logic                ser_data,
  input  logic                len24_sel,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid
);
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] held_word;
  logic                word_tog;

  rjrx_shift #(.W(SAMPLE_W)) u_shift (
    .bclk    (ser_bclk),
    .rst_n   (rst_n),
    .din     (ser_data),
    .shreg_o (shreg)
  );

  rjrx_wcap #(.W(SAMPLE_W), .SW(SHORT_W)) u_wcap (
    .wclk     (ser_wclk),
    .rst_n    (rst_n),
    .sel_long (len24_sel),
    .shreg_i  (shreg),
    .word_o   (held_word),
    .tog_o    (word_tog)
  );

  rjrx_cdc #(.W(SAMPLE_W), .STAGES(SYNC_DEPTH)) u_cdc (
    .clk     (clk_sys),
    .rst_n   (rst_n),
    .tog_i   (word_tog),
    .word_i  (held_word),
    .data_o  (smp_data),
    .valid_o (smp_valid)
  );
endmodule

// File: tb/rjrx_top_tb_top.sv
`timescale 1ns/1ps
module rjrx_top_tb_top;
  logic        clk_sys = 1'b0;
  logic        rst_n;
  logic        ser_bclk, ser_wclk, ser_data, len24_sel;
  logic [23:0] smp_data;
  logic        smp_valid;

  int checks = 0;
  int fails  = 0;
  int pushed = 0;
  int popped = 0;
  int stray  = 0;
  int wide   = 0;
  bit mon_on = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk_sys = ~clk_sys;

  rjrx_top dut_i (
    .clk_sys   (clk_sys),
    .rst_n     (rst_n),
    .ser_bclk  (ser_bclk),
    .ser_wclk  (ser_wclk),
    .ser_data  (ser_data),
    .len24_sel (len24_sel),
    .smp_data  (smp_data),
    .smp_valid (smp_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    ser_data = b;
    #10 ser_bclk = 1'b1;
    #20 ser_bclk = 1'b0;
    #10;
  endtask

  // Driver: optional leading junk bits, the word MSB first, idle gap, closing edge.
  task automatic send_word(input logic [23:0] val, input bit long24, input int extra,
                           input int gap, input string tag);
    int nb;
    logic [23:0] exp;
    nb = long24 ? 24 : 20;
    for (int i = 0; i < extra; i++) bit_out(~val[(nb-1) - (i % nb)] ^ i[0]);
    for (int i = nb - 1; i >= 0; i--) bit_out(val[i]);
    len24_sel = long24;
    exp = long24 ? val : {val[19:0], 4'h0};
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    pushed++;
    #(gap);
    ser_wclk = 1'b1;
    #60 ser_wclk = 1'b0;
    #40;
  endtask

  // Monitor / scoreboard
  logic [23:0] last_data = '0;
  logic        last_valid = 1'b0;
  always @(negedge clk_sys) begin
    if (mon_on) begin
      if (smp_valid && last_valid) wide++;
      if (!smp_valid && smp_data !== last_data) stray++;
      if (smp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected valid", smp_data, 24'h0);
        end else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          popped++;
          check(smp_data === e, t, smp_data, e);
        end
      end
      last_data  = smp_data;
      last_valid = smp_valid;
    end
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", popped, pushed);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_bclk = 1'b0; ser_wclk = 1'b0; ser_data = 1'b0; len24_sel = 1'b1;
    #42;
    // R8: reset state
    check(smp_valid === 1'b0, "R8 valid in reset", {23'h0, smp_valid}, 24'h0);
    check(smp_data === 24'h0, "R8 data in reset", smp_data, 24'h0);
    rst_n = 1'b1;
    #30 mon_on = 1'b1;

    send_word(24'h123456, 1'b1, 0, 10,  "R1 R2 24-bit mid value");
    send_word(24'h800000, 1'b1, 0, 10,  "R2 24-bit most negative");
    send_word(24'h7FFFFF, 1'b1, 3, 10,  "R4 24-bit with 3 leading junk bits");
    send_word(24'hFFFFFF, 1'b1, 0, 300, "R5 24-bit with long idle gap");
    send_word(24'h012345, 1'b0, 0, 10,  "R3 20-bit placed high");
    send_word(24'h080000, 1'b0, 0, 10,  "R3 20-bit most negative keeps sign");
    send_word(24'h0FFFFF, 1'b0, 4, 10,  "R4 20-bit with 4 leading junk bits");
    send_word(24'h07FFFF, 1'b0, 0, 500, "R5 20-bit with long idle gap");
    send_word(24'hA5A5A5, 1'b1, 0, 10,  "R9 switch back to 24-bit");
    send_word(24'h0C3C3C, 1'b0, 6, 10,  "R9 R4 switch to 20-bit with junk");
    send_word(24'h5A5A5A, 1'b1, 2, 150, "R9 R5 24-bit after 20-bit");
    send_word(24'h000001, 1'b1, 0, 10,  "R1 R2 LSB is last bit before edge");
    send_word(24'h000001, 1'b0, 0, 10,  "R1 R3 20-bit LSB on bit 4");

    #300;
    // R6: one pulse per word, never wider than a cycle
    check(popped == pushed && exp_q.size() == 0, "R6 pulse count", popped[23:0], pushed[23:0]);
    check(wide == 0, "R6 valid wider than one cycle", wide[23:0], 24'h0);
    // R7: no data change outside a valid cycle
    check(stray == 0, "R7 data changed without valid", stray[23:0], 24'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule